// File: doc/BRIEF.md
# Interleaved Slice Result Output Stage

This block sits at the back end of a time-interleaved converter built from sixteen parallel successive-approximation slices. Each slice presents a 9-bit result on a shared flat bus and raises its own transfer strobe when that result is ready. A free-running rotation pointer visits one slice per clock, in the same order in which the slices take their samples. The result of the visited slice is captured into the output register only if that slice is transferring in that cycle.

The captured result is turned into an 8-bit straight-binary word and an overrange flag. A result above the largest 8-bit code sets the flag and saturates the word to all ones. A data-valid strobe marks each cycle in which a new word was loaded. It stays low until the calibration sequencer reports completion.

An active-low enable controls the output pads. This block drives a pad output-enable line, and the pad cells place the data and overrange pins in high impedance when that line is low. The output register keeps updating while the pads are disabled.

Top module: `ilv_out_mux`

## Requirements
- R1: While `rst` is high at a rising edge, the register loaded at that edge holds `dout` = 0, `ovr` = 0 and `dvalid` = 0.
- R2: While `cal_done` is low, `dvalid` stays low and the output word is not reloaded, whatever the transfer strobes do.
- R3: With `cal_done` high, if the slice visited in a cycle has its `slice_xfer` bit set, then after the next rising edge `dout` shows that slice's result and `dvalid` is 1. Slice i occupies bits [9*i+8 : 9*i] of `slice_res`.
- R4: A transfer strobe from any slice other than the one visited in that cycle is ignored. In that case `dvalid` is 0 and `dout`/`ovr` keep their previous values.
- R5: A captured result above 255 (bit 8 set) gives `ovr` = 1 and `dout` = 8'hFF.
- R6: A captured result from 0 to 255 gives `ovr` = 0 and `dout` equal to the result's low eight bits. This includes exactly 255, which gives 8'hFF.
- R7: `pad_oe` is the inverse of `en_n`. The output register keeps loading while `en_n` is high, so re-enabling shows the latest word.
- R8: The first rising edge after reset is released visits slice 0. Each later edge visits the next slice, and the visit after slice 15 is slice 0.
- R9: Asserting `rst` in the middle of operation clears the outputs and restarts the rotation at slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Calibration sequencer reports completion |
| slice_res | input | 144 | Sixteen 9-bit slice results, slice i at bits [9i+8:9i] |
| slice_xfer | input | 16 | Per-slice transfer strobe |
| en_n | input | 1 | Active-low output enable |
| dout | output | 8 | Registered straight-binary word, bit 0 is LSB |
| ovr | output | 1 | Registered overrange flag |
| dvalid | output | 1 | High for one cycle per newly loaded word |
| pad_oe | output | 1 | Output-enable line toward the data and overrange pads |

## Verification
The rotation pointer runs free and cannot be read at the ports. The hardest case to reach is therefore a strobe that arrives on exactly the visited slice, or on purpose on a different one. The bench keeps its own count of rising edges since reset was released and uses it as the expected slot. It drives each slice's result and strobe just before the edge at which that slot is visited. Overrange, exactly full scale and a strobe on the wrong slice are all placed this way. A mid-run reset then checks that the count starts again at slice 0.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    parameter int NSLICE = 16;
    parameter int RES_W  = 9;
    parameter int OUT_W  = 8;

    localparam int PTR_W   = $clog2(NSLICE);
    localparam int BUS_W   = NSLICE * RES_W;
    localparam int MAXCODE = (1 << OUT_W) - 1;

    typedef logic [PTR_W-1:0] slot_t;
    typedef logic [RES_W-1:0] res_t;

    typedef struct packed {
        logic             ovr;
        logic [OUT_W-1:0] code;
    } out_word_t;

    // Clamp a slice result into the output code space.
    function automatic out_word_t saturate(input res_t r);
        out_word_t w;
        if (r > res_t'(MAXCODE)) begin
            w.ovr  = 1'b1;
            w.code = '1;
        end else begin
            w.ovr  = 1'b0;
            w.code = r[OUT_W-1:0];
        end
        return w;
    endfunction

    function automatic slot_t next_slot(input slot_t s);
        return (s == slot_t'(NSLICE - 1)) ? '0 : s + slot_t'(1);
    endfunction

endpackage

// File: rtl/ilv_rotator.sv
module ilv_rotator
    import ilv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot
);
    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= next_slot(slot_q);
    end

    assign slot = slot_q;
endmodule

// File: rtl/ilv_slice_sel.sv
module ilv_slice_sel
    import ilv_pkg::*;
(
    input  logic [BUS_W-1:0]  res_bus,
    input  logic [NSLICE-1:0] xfer,
    input  slot_t             slot,
    output res_t              sel_res,
    output logic              sel_xfer
);
    res_t lanes [NSLICE];

    for (genvar i = 0; i < NSLICE; i++) begin : g_lane
        assign lanes[i] = res_bus[i*RES_W +: RES_W];
    end

    always_comb begin
        sel_res  = '0;
        sel_xfer = 1'b0;
        for (int i = 0; i < NSLICE; i++) begin
            if (slot == slot_t'(i)) begin
                sel_res  = lanes[i];
                sel_xfer = xfer[i];
            end
        end
    end
endmodule

// File: rtl/ilv_out_reg.sv
module ilv_out_reg
    import ilv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  res_t      res,
    output out_word_t word,
    output logic      valid
);
    out_word_t word_q;
    logic      valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) word_q <= saturate(res);
        end
    end

    assign word  = word_q;
    assign valid = valid_q;
endmodule

// File: rtl/ilv_out_mux.sv
module ilv_out_mux
    import ilv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_done,
    input  logic [NSLICE*RES_W-1:0] slice_res,
    input  logic [NSLICE-1:0]       slice_xfer,
    input  logic                    en_n,
    output logic [OUT_W-1:0]        dout,
    output logic                    ovr,
    output logic                    dvalid,
    output logic                    pad_oe
);
    slot_t     slot;
    res_t      sel_res;
    logic      sel_xfer;
    out_word_t word;

    ilv_rotator u_rot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    ilv_slice_sel u_sel (
        .res_bus  (slice_res),
        .xfer     (slice_xfer),
        .slot     (slot),
        .sel_res  (sel_res),
        .sel_xfer (sel_xfer)
    );

    ilv_out_reg u_oreg (
        .clk   (clk),
        .rst   (rst),
        .load  (cal_done & sel_xfer),
        .res   (sel_res),
        .word  (word),
        .valid (dvalid)
    );

    assign dout   = word.code;
    assign ovr    = word.ovr;
    assign pad_oe = ~en_n;
endmodule

// File: rtl/ilv_out_mux_chk.sv
module ilv_out_mux_chk
    import ilv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cal_done,
    input logic [OUT_W-1:0] dout,
    input logic             ovr,
    input logic             dvalid,
    input slot_t            slot
);
    logic ok = 1'b0;
    always_ff @(posedge clk) ok <= !rst;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!dvalid && !ovr && dout == '0));

    assert_no_valid_precal_R2: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> !dvalid);

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (ok && !dvalid) |-> ($stable(dout) && $stable(ovr)));

    assert_ovr_saturates_R5: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (dout == '1));

    assert_rotation_R8: assert property (@(posedge clk) disable iff (rst)
        ok |-> (slot == next_slot($past(slot))));
endmodule

bind ilv_out_mux ilv_out_mux_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cal_done (cal_done),
    .dout     (dout),
    .ovr      (ovr),
    .dvalid   (dvalid),
    .slot     (slot)
);

// File: tb/ilv_out_mux_test.sv
`timescale 1ns/1ps
module ilv_out_mux_test;
    import ilv_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cal_done = 1'b0;
    logic [BUS_W-1:0] slice_res = '0;
    logic [NSLICE-1:0] slice_xfer = '0;
    logic             en_n = 1'b0;
    logic [OUT_W-1:0] dout;
    logic             ovr, dvalid, pad_oe;

    int checks = 0;
    int failures = 0;
    int bslot = 0;

    always #4 clk = ~clk;

    ilv_out_mux uut (
        .clk(clk), .rst(rst), .cal_done(cal_done), .slice_res(slice_res),
        .slice_xfer(slice_xfer), .en_n(en_n), .dout(dout), .ovr(ovr),
        .dvalid(dvalid), .pad_oe(pad_oe)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        bslot = rst ? 0 : (bslot + 1) % NSLICE;
        @(negedge clk);
    endtask

    task automatic set_res(input int s, input int v);
        slice_res[s*RES_W +: RES_W] = res_t'(v);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        bslot = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(dout == 0 && !ovr && !dvalid, "R1 reset state", {dvalid, ovr, dout}, 0);
    endtask

    task automatic t_precal();
        cal_done = 1'b0;
        for (int s = 0; s < NSLICE; s++) set_res(s, 8'h55);
        slice_xfer = '1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(!dvalid && dout == 0, "R2 no valid before cal", {dvalid, dout}, 0);
        end
        slice_xfer = '0;
    endtask

    task automatic t_rotation_start();
        do_reset();
        cal_done = 1'b1;
        for (int s = 0; s < NSLICE; s++) set_res(s, s * 7 + 3);
        slice_xfer = '1;
        tick();
        chk(dout == 3 && dvalid, "R8 first visit is slice 0", dout, 3);
    endtask

    task automatic t_select();
        for (int k = 0; k < 20; k++) begin
            int exp = bslot * 7 + 3;
            tick();
            chk(dvalid && dout == exp[7:0] && !ovr, "R3 selected slice word", dout, exp);
        end
        slice_xfer = '0;
    endtask

    task automatic t_ignore();
        slice_xfer = '0;
        set_res(bslot, 8'hEE);
        tick();
        chk(!dvalid, "R3 no strobe no valid", dvalid, 0);
        begin
            int held = dout;
            for (int s = 0; s < NSLICE; s++) set_res(s, 8'hA1);
            slice_xfer[(bslot + 5) % NSLICE] = 1'b1;
            tick();
            chk(!dvalid && dout == held, "R4 foreign strobe ignored", dout, held);
            slice_xfer = '0;
        end
    endtask

    task automatic hit(input int v);
        slice_xfer = '0;
        set_res(bslot, v);
        slice_xfer[bslot] = 1'b1;
        tick();
        slice_xfer = '0;
    endtask

    task automatic t_ovr();
        hit(9'h1A5);
        chk(ovr && dout == 8'hFF && dvalid, "R5 overrange saturates", {ovr, dout}, 9'h1FF);
        hit(9'h0FF);
        chk(!ovr && dout == 8'hFF, "R6 exact full scale", {ovr, dout}, 9'h0FF);
        hit(9'h000);
        chk(!ovr && dout == 8'h00, "R6 zero code", {ovr, dout}, 0);
        hit(9'h100);
        chk(ovr && dout == 8'hFF, "R5 just over full scale", {ovr, dout}, 9'h1FF);
        hit(9'h080);
        chk(!ovr && dout == 8'h80, "R6 mid scale clears ovr", {ovr, dout}, 9'h080);
    endtask

    task automatic t_oe();
        en_n = 1'b1;
        #1;
        chk(!pad_oe, "R7 pads disabled", pad_oe, 0);
        hit(9'h042);
        en_n = 1'b0;
        #1;
        chk(pad_oe && dout == 8'h42, "R7 reenable shows latest", {pad_oe, dout}, 9'h142);
    endtask

    task automatic t_reset_mid();
        for (int s = 0; s < NSLICE; s++) set_res(s, s + 16);
        tick(); tick(); tick();
        rst = 1'b1;
        tick();
        chk(dout == 0 && !ovr && !dvalid, "R9 mid-run reset clears", {dvalid, ovr, dout}, 0);
        rst = 1'b0;
        bslot = 0;
        slice_xfer = '1;
        tick();
        chk(dout == 16 && dvalid, "R9 rotation restarts at slice 0", dout, 16);
        slice_xfer = '0;
    endtask

    initial begin : watchdog
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_precal();
        t_rotation_start();
        t_select();
        t_ignore();
        t_ovr();
        t_oe();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule